// File: doc/BRIEF.md
# Packed Instruction Issue Controller

This block sits between instruction fetch and the execute stage of a small pipelined processor. Fetch hands it 32-bit instruction words. A word with its top bit set carries two 15-bit short instructions. Any other word is one full instruction. The controller holds one word at a time and presents exactly one instruction per issue slot. Each short instruction is widened into the full internal instruction format before it goes out.

The controller also arbitrates issue against four things: a pending interrupt, a halt request, a pipeline clear and a break instruction. Interrupts are switched to only on whole-word boundaries. The interrupt stall is therefore withheld while the second half of a packed word is still owed, so the processor can never stop partway through a word. When the processor is running and nothing else claims the slot, a ready execute stage always receives the waiting instruction.

Top module: `pkd_issue_ctrl`

## Requirements
- R1: A word with bit 31 set is packed. Its first short instruction is bits 30:16 and its second is bits 14:0. They issue in that order, one per slot. Bit 15 is ignored.
- R2: A short instruction carries its opcode in bits 14:12, its register in bits 11:8 and a signed immediate in bits 7:0. It expands to a full instruction laid out as follows: bit 31 = 0, bits 30:25 = full opcode, bits 24:21 = register, bits 20:0 = the sign-extended immediate. The short opcodes 0..7 (SUB, AND, ADD, CMP, LW, SW, LDI, MOV) map to the full opcodes 0x00, 0x01, 0x02, 0x03, 0x12, 0x13, 0x18 and 0x0D.
- R3: A word with bit 31 clear issues unchanged.
- R4: `word_take` accepts a new word only when the buffer is empty or the last instruction of the held word is issuing in that cycle. It is never high while the second half of a packed word is still to issue.
- R5: `irq_switch` is high only at a word boundary, meaning the second half of a packed word is not pending. In a switch cycle nothing issues, no word is taken, and the held word is discarded.
- R6: A pending interrupt holds back issue only at a word boundary. The second half of a packed word still issues while an interrupt is pending.
- R7: An unpacked word whose bits 30:25 equal 0x1C is a break. It raises `brk_stop`, is never issued, and stays held until a pipeline clear.
- R8: While reset is asserted, while `halt_req` is high, or during a `pipe_clear`, nothing issues and no word is taken. A halt keeps the held instruction for later.
- R9: A pipeline clear discards the held word. Issue restarts with the whole word, or the first half, of the next word taken.
- R10: With a valid instruction held, no halt, no clear, no pending interrupt, no break and `exec_ready` high, the instruction issues in that cycle.
- R11: `issue_stall` is high exactly when an instruction is held but does not leave in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Fetch offers a word |
| word_in | input | 32 | Offered instruction word |
| word_take | output | 1 | Offered word is taken at this edge |
| irq_pending | input | 1 | An interrupt is waiting |
| exec_ready | input | 1 | Execute stage can accept an instruction |
| halt_req | input | 1 | Processor halted |
| pipe_clear | input | 1 | Flush held word |
| issue_insn | output | 32 | Instruction presented to execute, full format |
| issue_valid | output | 1 | `issue_insn` is offered this cycle |
| issue_stall | output | 1 | Held instruction does not leave this cycle |
| irq_switch | output | 1 | Switch to interrupt context this cycle |
| brk_stop | output | 1 | A break instruction is blocking issue |

## Verification
The split and expansion are swept over every pair of short opcodes. Register and immediate values vary so that both signs of the immediate appear. This separates a swapped half order, a wrong opcode map and a wrong sign extension. Unpacked words are tried back to back to check that a word is taken in the same cycle the last instruction leaves. Interrupts are raised in two places: before the first half of a packed word, where the switch must happen and the word must be lost, and after the first half, where the second half must still issue first. Halt, clear, a stalled execute stage and a break word are each applied partway through a word, to show which instruction comes out next.

// File: rtl/pkd_issue_pkg.sv
package pkd_issue_pkg;
  localparam int WORD_W = 32;
  localparam int SUB_W  = 15;
  localparam int SOP_W  = 3;
  localparam int REG_W  = 4;
  localparam int SIMM_W = 8;
  localparam int FOP_W  = 6;
  localparam int FIMM_W = WORD_W - 1 - FOP_W - REG_W;
  localparam int HI_LSB = SUB_W + 1;

  typedef enum logic [SOP_W-1:0] {
    S_SUB, S_AND, S_ADD, S_CMP, S_LW, S_SW, S_LDI, S_MOV
  } sub_op_e;

  localparam logic [FOP_W-1:0] FOP_BRK = 6'h1C;

  function automatic logic [FOP_W-1:0] full_op(input sub_op_e o);
    case (o)
      S_SUB:   return 6'h00;
      S_AND:   return 6'h01;
      S_ADD:   return 6'h02;
      S_CMP:   return 6'h03;
      S_LW:    return 6'h12;
      S_SW:    return 6'h13;
      S_LDI:   return 6'h18;
      default: return 6'h0D;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] expand_sub(input logic [SUB_W-1:0] s);
    logic [SOP_W-1:0] op;
    op = s[SUB_W-1 -: SOP_W];
    return {1'b0, full_op(sub_op_e'(op)), s[SIMM_W+REG_W-1 -: REG_W],
            {(FIMM_W-SIMM_W){s[SIMM_W-1]}}, s[SIMM_W-1:0]};
  endfunction
endpackage

// File: rtl/pkd_word_split.sv
module pkd_word_split
  import pkd_issue_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              half,
  output logic [WORD_W-1:0] insn,
  output logic              packed_w,
  output logic              last,
  output logic              brk
);
  logic [SUB_W-1:0] first_s, second_s;

  assign packed_w = word[WORD_W-1];
  assign first_s  = word[HI_LSB +: SUB_W];
  assign second_s = word[SUB_W-1:0];
  assign insn     = packed_w ? expand_sub(half ? second_s : first_s) : word;
  assign last     = !packed_w || half;
  assign brk      = !packed_w && (word[WORD_W-2 -: FOP_W] == FOP_BRK);
endmodule

// File: rtl/pkd_half_track.sv
module pkd_half_track
  import pkd_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic              fire,
  input  logic              last,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] cur_word,
  output logic              cur_valid,
  output logic              half
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_word  <= '0;
      cur_valid <= 1'b0;
      half      <= 1'b0;
    end else if (flush) begin
      cur_valid <= 1'b0;
      half      <= 1'b0;
    end else if (take) begin
      cur_word  <= word_in;
      cur_valid <= 1'b1;
      half      <= 1'b0;
    end else if (fire) begin
      if (last) begin
        cur_valid <= 1'b0;
        half      <= 1'b0;
      end else begin
        half <= 1'b1;
      end
    end
  end

  // R1
  half_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> cur_valid);
  // R9
  fresh_word_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cur_valid && !half));
  // R4
  no_take_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !fire) |-> !take);
endmodule

// File: rtl/pkd_issue_arb.sv
module pkd_issue_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_valid,
  input  logic half,
  input  logic last,
  input  logic brk,
  input  logic word_valid,
  input  logic irq_pending,
  input  logic exec_ready,
  input  logic halt_req,
  input  logic pipe_clear,
  output logic issue_valid,
  output logic fire,
  output logic issue_stall,
  output logic irq_switch,
  output logic take,
  output logic brk_stop
);
  logic blocked, irq_hold;

  assign blocked     = !rst_n || halt_req || pipe_clear;
  assign irq_hold    = irq_pending && !half;
  assign irq_switch  = irq_hold && !blocked;
  assign brk_stop    = cur_valid && brk;
  assign issue_valid = cur_valid && !blocked && !brk && !irq_hold;
  assign fire        = issue_valid && exec_ready;
  assign issue_stall = cur_valid && !fire;
  assign take        = word_valid && !blocked && !irq_switch &&
                       (!cur_valid || (fire && last));

  // R5
  irq_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_switch |-> (!half && !issue_valid && !take));
  // R7
  brk_never_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_stop |-> !issue_valid);
  // R8
  halt_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || pipe_clear) |-> (!issue_valid && !take));
  // R10
  no_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_valid && !halt_req && !pipe_clear && !irq_pending && !brk && exec_ready)
      |-> fire);
  // R6
  second_half_goes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half && !halt_req && !pipe_clear && exec_ready) |-> fire);
endmodule

// File: rtl/pkd_issue_ctrl.sv
module pkd_issue_ctrl
  import pkd_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_take,
  input  logic              irq_pending,
  input  logic              exec_ready,
  input  logic              halt_req,
  input  logic              pipe_clear,
  output logic [WORD_W-1:0] issue_insn,
  output logic              issue_valid,
  output logic              issue_stall,
  output logic              irq_switch,
  output logic              brk_stop
);
  logic [WORD_W-1:0] cur_word;
  logic cur_valid, half, packed_w, last, brk, fire;

  pkd_word_split u_split (
    .word(cur_word), .half(half), .insn(issue_insn),
    .packed_w(packed_w), .last(last), .brk(brk)
  );

  pkd_half_track u_track (
    .clk(clk), .rst_n(rst_n), .flush(pipe_clear || irq_switch),
    .take(word_take), .fire(fire), .last(last), .word_in(word_in),
    .cur_word(cur_word), .cur_valid(cur_valid), .half(half)
  );

  pkd_issue_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .half(half),
    .last(last), .brk(brk), .word_valid(word_valid),
    .irq_pending(irq_pending), .exec_ready(exec_ready),
    .halt_req(halt_req), .pipe_clear(pipe_clear),
    .issue_valid(issue_valid), .fire(fire), .issue_stall(issue_stall),
    .irq_switch(irq_switch), .take(word_take), .brk_stop(brk_stop)
  );

  // R5
  irq_drops_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_switch |=> !cur_valid);
  // R1
  half_only_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> packed_w);
endmodule

// File: tb/pkd_issue_ctrl_test.sv
`timescale 1ns/1ps
module pkd_issue_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0, exec_ready = 1'b0, irq_pending = 1'b0;
  logic halt_req = 1'b0, pipe_clear = 1'b0;
  logic [31:0] word_in = '0;
  logic word_take, issue_valid, issue_stall, irq_switch, brk_stop;
  logic [31:0] issue_insn;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkd_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .word_take(word_take), .irq_pending(irq_pending), .exec_ready(exec_ready),
    .halt_req(halt_req), .pipe_clear(pipe_clear), .issue_insn(issue_insn),
    .issue_valid(issue_valid), .issue_stall(issue_stall),
    .irq_switch(irq_switch), .brk_stop(brk_stop)
  );

  function automatic logic [31:0] widen(input logic [14:0] s);
    int codes [8] = '{0, 1, 2, 3, 18, 19, 24, 13};
    int imm, v;
    imm = (s[7:0] >= 128) ? int'(s[7:0]) - 256 : int'(s[7:0]);
    v = codes[s[14:12]] * (1 << 25) + int'(s[11:8]) * (1 << 21) + (imm & 32'h1FFFFF);
    return 32'(v);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drv(input logic wv, input logic [31:0] w, input logic er,
                     input logic irq, input logic hlt, input logic clr);
    @(negedge clk);
    word_valid = wv; word_in = w; exec_ready = er;
    irq_pending = irq; halt_req = hlt; pipe_clear = clr;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, p;
    // R8 reset blocks everything
    drv(1, 32'h0440_1234, 1, 1, 0, 0);
    chk("R8 reset valid", issue_valid, 0);
    chk("R8 reset take", word_take, 0);
    chk("R8 reset irq", irq_switch, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R4 R10 unpacked back to back
    drv(1, 32'h0440_1234, 1, 0, 0, 0);
    chk("R4 take empty", word_take, 1);
    chk("R11 empty no stall", issue_stall, 0);
    drv(1, 32'h0A21_5678, 1, 0, 0, 0);
    chk("R3 insn", issue_insn, 32'h0440_1234);
    chk("R10 valid", issue_valid, 1);
    chk("R4 take on last", word_take, 1);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R3 insn2", issue_insn, 32'h0A21_5678);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R11 drained", issue_valid | issue_stall, 0);

    // R1 R2 sweep over all opcode pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [14:0] sa, sb;
        sa = {3'(a), 4'((a * 3 + b) & 15), 8'((a * 37 + b * 11) & 255)};
        sb = {3'(b), 4'((b * 5 + a) & 15), 8'((b * 71 + a * 29 + 128) & 255)};
        w = {1'b1, sa, 1'(b & 1), sb};
        drv(1, w, 1, 0, 0, 0);
        drv(1, 32'hFFFF_FFFF, 1, 0, 0, 0);
        chk("R1 R2 first half", issue_insn, widen(sa));
        chk("R4 no take mid word", word_take, 0);
        drv(0, 32'h0, 1, 0, 0, 0);
        chk("R1 R2 second half", issue_insn, widen(sb));
      end
    end
    drv(0, 32'h0, 1, 0, 0, 0);

    // R11 execute not ready
    drv(1, 32'h0660_00AA, 0, 0, 0, 0);
    drv(0, 32'h0, 0, 0, 0, 0);
    chk("R11 stall", issue_stall, 1);
    drv(0, 32'h0, 0, 0, 0, 0);
    chk("R11 held insn", issue_insn, 32'h0660_00AA);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R11 leaves", issue_stall, 0);

    // R8 halt mid packed word
    p = {1'b1, 15'h2345, 1'b0, 15'h6F80};
    drv(1, p, 1, 0, 0, 0);
    drv(0, 32'h0, 1, 0, 0, 0);
    drv(1, 32'h0123_4567, 1, 0, 1, 0);
    chk("R8 halt valid", issue_valid, 0);
    chk("R8 halt take", word_take, 0);
    chk("R8 halt stall", issue_stall, 1);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R8 resume second", issue_insn, widen(15'h6F80));
    chk("R8 resume valid", issue_valid, 1);

    // R6 R5 interrupt after first half
    p = {1'b1, 15'h1281, 1'b0, 15'h7FFF};
    drv(1, p, 1, 0, 0, 0);
    drv(0, 32'h0, 1, 0, 0, 0);
    drv(0, 32'h0, 1, 1, 0, 0);
    chk("R6 second half issues", issue_valid, 1);
    chk("R6 second half insn", issue_insn, widen(15'h7FFF));
    chk("R5 no switch mid word", irq_switch, 0);
    drv(0, 32'h0, 1, 1, 0, 0);
    chk("R5 switch at boundary", irq_switch, 1);
    chk("R5 nothing issued", issue_valid, 0);

    // R5 interrupt before first half discards the word
    drv(1, {1'b1, 15'h3333, 1'b0, 15'h4444}, 1, 0, 0, 0);
    drv(1, 32'h0555_0000, 1, 1, 0, 0);
    chk("R5 switch on whole word", irq_switch, 1);
    chk("R5 no issue", issue_valid, 0);
    chk("R5 no take", word_take, 0);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R5 word dropped", issue_valid | issue_stall, 0);

    // R9 clear mid word, restart on first half
    drv(1, {1'b1, 15'h0F0F, 1'b0, 15'h7070}, 1, 0, 0, 0);
    drv(0, 32'h0, 1, 0, 0, 0);
    drv(1, 32'h0, 1, 0, 0, 1);
    chk("R8 clear valid", issue_valid, 0);
    drv(1, {1'b1, 15'h5A5A, 1'b0, 15'h2B2B}, 1, 0, 0, 0);
    chk("R9 dropped", issue_valid, 0);
    chk("R9 take new", word_take, 1);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R9 restart first", issue_insn, widen(15'h5A5A));

    // R7 break
    drv(0, 32'h0, 1, 0, 0, 0);
    drv(1, {1'b0, 6'h1C, 25'h0}, 1, 0, 0, 0);
    drv(1, 32'h0440_0001, 1, 0, 0, 0);
    chk("R7 stop", brk_stop, 1);
    chk("R7 not issued", issue_valid, 0);
    chk("R7 no take", word_take, 0);
    drv(1, 32'h0440_0001, 1, 0, 0, 0);
    chk("R7 still held", brk_stop, 1);
    drv(0, 32'h0, 1, 0, 0, 1);
    drv(0, 32'h0, 1, 0, 0, 0);
    chk("R7 released", brk_stop, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule